// File: doc/BRIEF.md
# Power-Fail Store Guard

This block sits between the host-side strobes of a battery-free nonvolatile SRAM and its array. It watches a low-supply flag coming from an external comparator and blocks every write while the supply is unsafe. It also refuses a write that was already in progress when the part came out of reset or a recall, or when a store finished. Such a write is held off until the host lifts one of its strobes. Blocking the write at power-up, after a recall and after a store keeps a half-powered bus from corrupting data.

The block also runs the store sequence that copies the SRAM into the nonvolatile cells. A store can be started in three ways: automatically when the supply falls through the switch threshold, by a software request pulse, or by another device pulling the shared store pin low. Every store begins with a fixed pull-down window on the open-drain store pin. At the end of the window the block reads the pin back. If the pin never went low, because something is holding it high, the attempt is abandoned. Otherwise the array store is requested and held until the array reports completion.

Top module: `pfs_store_guard`

## Requirements
- R1: In the idle state, with the supply good and no recall in progress, `arrayWrEn` equals `!ceN && !weN` in the same cycle, with no register in the path.
- R2: While the synchronized low-supply flag is high (two clocks after `lowSupplyAsync` rises), `arrayWrEn` is 0. A software request or a store-pin low arriving in that time starts no store.
- R3: After reset release, after a recall ends, or after a store or an aborted store, `arrayWrEn` stays 0 while both strobes remain low. Writes resume only after a clock edge at which `ceN` or `weN` was sampled high. While `recallActive` is 1, `arrayWrEn` is 0.
- R4: Every store attempt drives `storePullDown` high for exactly `CLK_HZ/1_000_000*PULL_US` consecutive cycles, starting one cycle after the trigger is seen.
- R5: With `autoInhibit` at 0, a rising edge of the synchronized low-supply flag starts a store.
- R6: If the synchronized store-pin level is high in the last pull-down cycle, the attempt is abandoned. The pin is released, `arrayStore` never rises, and `busy` falls one cycle after the pull-down ends.
- R7: With `autoInhibit` at 1, a supply drop starts no store. A one-cycle `swStoreReq` pulse, or a low on the store pin lasting at least one clock, still starts one.
- R8: After a successful pull-down window, `arrayStore` stays high until `arrayDone` is sampled high. `busy` is high from the first pull-down cycle to the last store cycle, and `arrayWrEn` is 0 throughout.
- R9: Store requests of any kind that arrive while `busy` is high are dropped and do not cause a second store afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lowSupplyAsync | input | 1 | Low-supply flag from the comparator, asynchronous, 1 = supply below threshold |
| ceN | input | 1 | Host chip enable, active low |
| weN | input | 1 | Host write enable, active low |
| storePinSense | input | 1 | Sensed level of the shared store pin, asynchronous |
| swStoreReq | input | 1 | One-cycle software store request |
| autoInhibit | input | 1 | 1 = supply-drop trigger disabled |
| recallActive | input | 1 | High while the array runs a recall |
| arrayDone | input | 1 | Array reports the store is complete |
| arrayWrEn | output | 1 | Gated write enable to the SRAM array, active high |
| storePullDown | output | 1 | Enable of the open-drain pull-down on the store pin |
| arrayStore | output | 1 | Store request held to the array until done |
| busy | output | 1 | A store attempt is in progress |

## Verification
A wrong internal state shows on the same cycle at `arrayWrEn`, because that output is combinational from the state and the strobes. A guard that forgets to hold a stale write shows up as a write pulse the first time the strobes are sampled after reset, recall or store end. A pull-down counter that is off by one changes the length of `storePullDown` by a cycle, which the bench measures exactly. A wrong decision at the pin read-back appears within a cycle of the pull-down ending, either as `arrayStore` rising after an attempt that should have been abandoned or as `busy` falling early. A request leaking through while busy would show up as a second `busy` period tens of cycles after the first.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULL,
    ST_CHECK,
    ST_STORE,
    ST_ABORT,
    ST_HOLD
  } guardState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntEn;
  } dpCtrl_t;

  // conditioned status from datapath to control
  typedef struct packed {
    logic lowLevel;
    logic lowRise;
    logic pinLow;
    logic pinFall;
    logic cntDone;
  } dpStat_t;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= RESET_VAL;
        else       chain[i] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= RESET_VAL;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pfs_datapath.sv
module pfs_datapath
  import pfs_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int PULL_US     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lowSupplyAsync,
  input  logic    storePinSense,
  input  dpCtrl_t ctrl,
  output dpStat_t stat
);
  localparam int PULL_CYCLES = (CLK_HZ / 1_000_000) * PULL_US;
  localparam int CNT_W       = (PULL_CYCLES > 2) ? $clog2(PULL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULL_CYCLES - 2);

  logic lowSync, lowPrev;
  logic pinSync, pinPrev;
  logic [CNT_W-1:0] pullCnt;

  // supply flag assumed low-supply during reset so power-up gives no rising edge
  pfs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_lowSync (
    .clk(clk), .rstN(rstN), .asyncIn(lowSupplyAsync), .syncOut(lowSync)
  );

  // released store pin reads high
  pfs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pinSync (
    .clk(clk), .rstN(rstN), .asyncIn(storePinSense), .syncOut(pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowPrev <= 1'b1;
      pinPrev <= 1'b1;
    end else begin
      lowPrev <= lowSync;
      pinPrev <= pinSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pullCnt <= '0;
    else if (ctrl.cntClr) pullCnt <= '0;
    else if (ctrl.cntEn)  pullCnt <= pullCnt + 1'b1;
  end

  always_comb begin
    stat.lowLevel = lowSync;
    stat.lowRise  = lowSync & ~lowPrev;
    stat.pinLow   = ~pinSync;
    stat.pinFall  = pinPrev & ~pinSync;
    stat.cntDone  = ctrl.cntEn & (pullCnt == CNT_LAST);
  end
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStat_t     stat,
  input  logic        ceN,
  input  logic        weN,
  input  logic        swStoreReq,
  input  logic        autoInhibit,
  input  logic        recallActive,
  input  logic        arrayDone,
  output dpCtrl_t     ctrl,
  output guardState_e state,
  output logic        arrayWrEn,
  output logic        storePullDown,
  output logic        arrayStore,
  output logic        busy
);
  guardState_e nextState;
  logic extReq, autoReq, canStart, startReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;   // a write pending at power-up is held
    else       state <= nextState;
  end

  always_comb begin
    extReq   = (swStoreReq | stat.pinFall) & ~stat.lowLevel;
    autoReq  = stat.lowRise & ~autoInhibit;
    canStart = (state == ST_IDLE) | (state == ST_HOLD);
    startReq = canStart & (extReq | autoReq);

    nextState   = state;
    ctrl.cntClr = startReq;
    ctrl.cntEn  = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (startReq)          nextState = ST_PULL;
        else if (recallActive) nextState = ST_HOLD;
      end
      ST_HOLD: begin
        if (startReq)                          nextState = ST_PULL;
        else if (!recallActive && (ceN | weN)) nextState = ST_IDLE;
      end
      ST_PULL: begin
        ctrl.cntEn = 1'b1;
        if (stat.cntDone) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        nextState = stat.pinLow ? ST_STORE : ST_ABORT;
      end
      ST_STORE: begin
        if (arrayDone) nextState = ST_HOLD;
      end
      ST_ABORT: nextState = ST_HOLD;
      default:  nextState = ST_HOLD;
    endcase
  end

  // write gate: combinational so a blocked write never reaches the array
  always_comb begin
    arrayWrEn     = (state == ST_IDLE) & ~recallActive & ~stat.lowLevel & ~ceN & ~weN;
    storePullDown = (state == ST_PULL) | (state == ST_CHECK);
    arrayStore    = (state == ST_STORE);
    busy          = storePullDown | arrayStore | (state == ST_ABORT);
  end
endmodule

// File: rtl/pfs_store_guard.sv
module pfs_store_guard
  import pfs_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int PULL_US     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowSupplyAsync,
  input  logic ceN,
  input  logic weN,
  input  logic storePinSense,
  input  logic swStoreReq,
  input  logic autoInhibit,
  input  logic recallActive,
  input  logic arrayDone,
  output logic arrayWrEn,
  output logic storePullDown,
  output logic arrayStore,
  output logic busy
);
  localparam int PULL_CYCLES = (CLK_HZ / 1_000_000) * PULL_US;

  dpCtrl_t     dpCtrl;
  dpStat_t     dpStat;
  guardState_e guardState;

  pfs_datapath #(
    .CLK_HZ(CLK_HZ), .PULL_US(PULL_US), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .lowSupplyAsync(lowSupplyAsync), .storePinSense(storePinSense),
    .ctrl(dpCtrl), .stat(dpStat)
  );

  pfs_fsm u_fsm (
    .clk(clk), .rstN(rstN), .stat(dpStat),
    .ceN(ceN), .weN(weN), .swStoreReq(swStoreReq),
    .autoInhibit(autoInhibit), .recallActive(recallActive), .arrayDone(arrayDone),
    .ctrl(dpCtrl), .state(guardState),
    .arrayWrEn(arrayWrEn), .storePullDown(storePullDown),
    .arrayStore(arrayStore), .busy(busy)
  );
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int PULL_CYCLES = 1000
) (
  input logic clk,
  input logic rstN,
  input logic ceN,
  input logic weN,
  input logic lowLevel,
  input logic arrayWrEn,
  input logic storePullDown,
  input logic arrayStore,
  input logic arrayDone,
  input logic busy
);
  int pullRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pullRun <= 0;
    else if (storePullDown) pullRun <= pullRun + 1;
    else                    pullRun <= 0;
  end

  AST_WR_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    arrayWrEn |-> (!ceN && !weN)); // R1

  AST_WR_BLOCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    lowLevel |-> !arrayWrEn); // R2

  AST_HOLD_AFTER_STORE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !ceN && !weN) |-> !arrayWrEn); // R3

  AST_PULL_NOT_LONG: assert property (@(posedge clk) disable iff (!rstN)
    storePullDown |-> (pullRun < PULL_CYCLES)); // R4

  AST_PULL_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (!storePullDown && pullRun != 0) |-> (pullRun == PULL_CYCLES)); // R4

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(storePullDown) && !arrayStore) |=> !busy); // R6

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (arrayStore && !arrayDone) |=> arrayStore); // R8

  AST_NO_WR_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !arrayWrEn); // R8

  AST_PULL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (storePullDown || arrayStore) |-> busy); // R8
endmodule

bind pfs_store_guard pfs_checker #(.PULL_CYCLES(PULL_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN),
  .lowLevel(dpStat.lowLevel), .arrayWrEn(arrayWrEn),
  .storePullDown(storePullDown), .arrayStore(arrayStore),
  .arrayDone(arrayDone), .busy(busy)
);

// File: tb/sim_pfs_store_guard.sv
`timescale 1ns/1ps
module sim_pfs_store_guard;
  localparam int CLK_HZ  = 50_000_000;
  localparam int PULL_US = 20;
  localparam int PULL_EXP = (CLK_HZ / 1_000_000) * PULL_US;

  logic clk = 1'b0;
  logic rstN, lowSupplyAsync, ceN, weN, swStoreReq, autoInhibit, recallActive, arrayDone;
  logic extPullLow, pinForceHigh;
  wire  storePinSense;
  wire  arrayWrEn, storePullDown, arrayStore, busy;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // open-drain store pin: low if anyone pulls, unless a strong driver holds it high
  assign storePinSense = pinForceHigh | ~(storePullDown | extPullLow);

  pfs_store_guard #(.CLK_HZ(CLK_HZ), .PULL_US(PULL_US)) u0 (
    .clk(clk), .rstN(rstN), .lowSupplyAsync(lowSupplyAsync), .ceN(ceN), .weN(weN),
    .storePinSense(storePinSense), .swStoreReq(swStoreReq), .autoInhibit(autoInhibit),
    .recallActive(recallActive), .arrayDone(arrayDone),
    .arrayWrEn(arrayWrEn), .storePullDown(storePullDown),
    .arrayStore(arrayStore), .busy(busy)
  );

  function automatic logic expWr(input logic c, input logic w);
    return !c && !w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watch a store attempt: returns pull length, store seen, busy length, writes seen
  task automatic serviceStore(input int doneDelay, input bit inject,
                              output bit gotBusy, output int pullLen,
                              output bit stored, output int busyLen, output bit wrSeen);
    int storeCyc = 0;
    gotBusy = 0; pullLen = 0; stored = 0; busyLen = 0; wrSeen = 0;
    for (int i = 0; i < 10 && !busy; i++) cyc(1);
    gotBusy = busy;
    while (busy && busyLen < 5000) begin
      if (storePullDown) pullLen++;
      if (arrayWrEn) wrSeen = 1;
      if (arrayStore) begin
        stored = 1;
        storeCyc++;
        arrayDone = (storeCyc == doneDelay);
      end else arrayDone = 1'b0;
      swStoreReq = inject && (busyLen == 5);
      extPullLow = inject && (busyLen >= 5) && (busyLen < 8);
      busyLen++;
      cyc(1);
    end
    arrayDone = 1'b0; swStoreReq = 1'b0; extPullLow = 1'b0;
  endtask

  task automatic quietCheck(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (busy) seen = 1;
      cyc(1);
    end
    check(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit gb, st, wr;
    int pl, bl;
    void'($urandom(32'h1D5E_0042));
    rstN = 0; lowSupplyAsync = 0; ceN = 0; weN = 0; swStoreReq = 0;
    autoInhibit = 1; recallActive = 0; arrayDone = 0; extPullLow = 0; pinForceHigh = 0;
    cyc(3);
    check(!busy && !storePullDown && !arrayStore, "reset outputs idle", busy, 0);
    check(!arrayWrEn, "R3 write blocked in reset", arrayWrEn, 0);
    rstN = 1;
    cyc(6);
    check(!arrayWrEn, "R3 write held after power-up", arrayWrEn, 0);
    weN = 1; cyc(1); weN = 0; #1;
    check(arrayWrEn, "R3 write after fresh strobe edge", arrayWrEn, 1);
    cyc(1);

    // R1 random strobe patterns
    for (int i = 0; i < 40; i++) begin
      ceN = 1'($urandom % 2); weN = 1'($urandom % 2); #1;
      check(arrayWrEn == expWr(ceN, weN), "R1 gate follows strobes", arrayWrEn, expWr(ceN, weN));
      cyc(1);
    end

    // R2 low supply with supply-drop trigger inhibited
    ceN = 1; weN = 1; lowSupplyAsync = 1; cyc(4);
    ceN = 0; weN = 0; #1;
    check(!arrayWrEn, "R2 write blocked on low supply", arrayWrEn, 0);
    swStoreReq = 1; cyc(1); swStoreReq = 0;
    extPullLow = 1; cyc(1); extPullLow = 0;
    quietCheck(30, "R2 requests ignored on low supply");
    check(!busy, "R7 supply drop ignored when inhibited", busy, 0);
    lowSupplyAsync = 0; cyc(4);
    check(arrayWrEn, "R2 writes resume when supply good", arrayWrEn, 1);
    ceN = 1; weN = 1; cyc(1);

    // R7 software store
    swStoreReq = 1; cyc(1); swStoreReq = 0;
    serviceStore(4, 0, gb, pl, st, bl, wr);
    check(gb, "R7 software store starts", gb, 1);
    check(pl == PULL_EXP, "R4 pull length software", pl, PULL_EXP);
    check(st, "R8 array store after pull", st, 1);
    check(bl == PULL_EXP + 4, "R8 busy spans pull and store", bl, PULL_EXP + 4);
    cyc(3);

    // R7 store from an external low on the pin
    extPullLow = 1; cyc(1); extPullLow = 0;
    serviceStore(2, 0, gb, pl, st, bl, wr);
    check(gb && st, "R7 pin-started store", st, 1);
    check(pl == PULL_EXP, "R4 pull length pin", pl, PULL_EXP);
    cyc(3);

    // R5 automatic store on supply drop
    autoInhibit = 0; lowSupplyAsync = 1;
    serviceStore(3, 0, gb, pl, st, bl, wr);
    check(gb && st, "R5 autostore on supply drop", st, 1);
    check(pl == PULL_EXP, "R4 pull length auto", pl, PULL_EXP);
    ceN = 0; weN = 0; cyc(2); #1;
    check(!arrayWrEn, "R2 write blocked after autostore while low", arrayWrEn, 0);
    ceN = 1; weN = 1;
    lowSupplyAsync = 0; cyc(4);

    // R6 abort when pin held high
    pinForceHigh = 1; lowSupplyAsync = 1;
    serviceStore(3, 0, gb, pl, st, bl, wr);
    check(gb, "R6 attempt started", gb, 1);
    check(pl == PULL_EXP, "R4 pull length abort", pl, PULL_EXP);
    check(!st, "R6 no array store on abort", st, 0);
    check(bl == PULL_EXP + 1, "R6 busy ends one cycle after pull", bl, PULL_EXP + 1);
    pinForceHigh = 0; lowSupplyAsync = 0; cyc(4);

    // R7 supply drop with inhibit set
    autoInhibit = 1; lowSupplyAsync = 1;
    quietCheck(20, "R7 inhibited supply drop");
    lowSupplyAsync = 0; cyc(4);

    // R9 requests during a store are dropped
    swStoreReq = 1; cyc(1); swStoreReq = 0;
    serviceStore(6, 1, gb, pl, st, bl, wr);
    check(st, "R9 first store completes", st, 1);
    quietCheck(40, "R9 no second store");

    // R3 after a store, R8 no writes while busy
    ceN = 0; weN = 0;
    swStoreReq = 1; cyc(1); swStoreReq = 0;
    serviceStore(2, 0, gb, pl, st, bl, wr);
    check(!wr, "R8 no write while busy", wr, 0);
    #1;
    check(!arrayWrEn, "R3 write held at store end", arrayWrEn, 0);
    cyc(3);
    check(!arrayWrEn, "R3 write still held", arrayWrEn, 0);
    ceN = 1; cyc(1); ceN = 0; #1;
    check(arrayWrEn, "R3 write after fresh ce edge", arrayWrEn, 1);
    cyc(1);

    // R3 recall
    recallActive = 1; #1;
    check(!arrayWrEn, "R3 write blocked during recall", arrayWrEn, 0);
    cyc(5); recallActive = 0; cyc(3);
    check(!arrayWrEn, "R3 write held after recall", arrayWrEn, 0);
    weN = 1; cyc(1); weN = 0; #1;
    check(arrayWrEn, "R3 write after fresh we edge", arrayWrEn, 1);
    cyc(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule